// File: doc/BRIEF.md
# Glitch-Free Three-Source Clock Selector

This block picks the processor clock from one of three free-running sources: an external reference clock, a PLL output and an on-chip ring oscillator. Two control bits choose the source. The slow-clock bit has priority and forces the ring oscillator. When it is low, the PLL bit chooses between the external clock and the PLL. Each source feeds the output through its own gated path. A path opens only after every other path has closed, and each path's gate changes only while its own clock is low. A change of selection therefore leaves a low gap on the output. It never leaves a runt pulse.

The selector also manages the two sources that can be powered down. It raises the ring-oscillator enable only while that oscillator is wanted or still driving the output. Once the enable is up, it waits a settle count of oscillator cycles before it opens the ring path. It also guards the PLL: a request to power the PLL down while the PLL is selected or still driving the output is overridden, and a sticky error flag records the misuse. A one-hot status output reports which path currently drives the clock. Software is expected to wait at least two cycles after changing the slow-clock bit before it relies on the new clock.

Top module: `clk_source_sel`

## Requirements
- R1: While `rstN` is low, `srcActive` is 3'b000, `clkOut` is low, `pllErr` is low and `oscEn` is low when `slowSel` is low.
- R2: With `slowSel`=0 and `pllSel`=0, `srcActive` settles to 3'b001 (bit 0 = external), and `clkOut` follows `clkExt`.
- R3: With `slowSel`=0 and `pllSel`=1, `srcActive` settles to 3'b010 (bit 1 = PLL), and `clkOut` follows `clkPll`.
- R4: With `slowSel`=1, `srcActive` settles to 3'b100 (bit 2 = ring), and `clkOut` follows `clkRing` whatever `pllSel` holds.
- R5: `oscEn` is high whenever the ring path is active or `slowSel` is 1. It is low once another source is active and `slowSel` is 0.
- R6: At most one bit of `srcActive` is set at any time. No high or low phase of `clkOut` is shorter than the shortest half period among the sources it has carried.
- R7: The ring path opens no sooner than `SETTLE_CYCLES` ring-oscillator cycles after `oscEn` rises.
- R8: `pllEnOut` is high while the PLL is selected or its path is active, even if `pllEnReq` is low. Otherwise it equals `pllEnReq`.
- R9: `pllErr` is set when `pllEnReq` is low while the PLL is selected or active. It stays set until `rstN` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkExt | input | 1 | External reference clock |
| clkPll | input | 1 | PLL output clock |
| clkRing | input | 1 | Ring-oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slowSel | input | 1 | Selects the ring oscillator; has priority |
| pllSel | input | 1 | When slowSel is 0: 1 = PLL, 0 = external |
| pllEnReq | input | 1 | Requested PLL power state from software |
| oscEn | output | 1 | Power enable to the ring oscillator |
| pllEnOut | output | 1 | Guarded power enable to the PLL |
| clkOut | output | 1 | Selected, glitch-free processor clock |
| srcActive | output | 3 | One-hot active path: bit0 ext, bit1 PLL, bit2 ring |
| pllErr | output | 1 | Sticky flag: PLL power-down attempted while in use |

## Verification
On every reference-clock cycle, the assertions check that at most one path is open. They also check that an open ring path has a powered, settled oscillator, that an open PLL path keeps the PLL powered, and that the error flag never clears on its own. Only the bench scenarios can show the rest. These are the measured output period after each switch, the absence of short pulses across every transition, the settle delay timed from the oscillator enable, the override of `pllSel` by `slowSel`, and the error and power guard after a power-down request during PLL use.

// File: rtl/clk_source_sel_pkg.sv
`timescale 1ns/1ps
package clk_source_sel_pkg;
  localparam int NUM_SRC  = 3;
  localparam int SRC_EXT  = 0;
  localparam int SRC_PLL  = 1;
  localparam int SRC_RING = 2;

  typedef struct packed {
    logic [NUM_SRC-1:0] pathReq;
  } selStrobes_t;
endpackage

// File: rtl/clk_source_sel_ctrl.sv
`timescale 1ns/1ps
module clk_source_sel_ctrl
  import clk_source_sel_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic               clkPll,
  input  logic               clkRing,
  input  logic               rstN,
  input  logic               slowSel,
  input  logic               pllSel,
  input  logic               pllEnReq,
  input  logic [NUM_SRC-1:0] pathEn,
  output selStrobes_t        strobes,
  output logic               oscEn,
  output logic               pllEnOut,
  output logic               pllErr,
  output logic               settleDone
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CYCLES);

  logic [NUM_SRC-1:0] wantSrc;
  logic [CNT_W-1:0]   settleCnt;
  logic               settleRstN;
  logic               pllInUse;

  // priority decode: slow-clock bit overrides the PLL bit
  always_comb begin
    wantSrc = '0;
    if (slowSel)     wantSrc[SRC_RING] = 1'b1;
    else if (pllSel) wantSrc[SRC_PLL]  = 1'b1;
    else             wantSrc[SRC_EXT]  = 1'b1;
  end

  // oscillator stays powered while wanted or while its path is still open
  assign oscEn      = slowSel | pathEn[SRC_RING];
  assign settleRstN = rstN & oscEn;

  always_ff @(posedge clkRing or negedge settleRstN) begin
    if (!settleRstN)            settleCnt <= '0;
    else if (settleCnt != CNT_MAX) settleCnt <= settleCnt + 1'b1;
  end
  assign settleDone = (settleCnt == CNT_MAX);

  // break-before-make: a path may open only when all others are closed
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      strobes.pathReq[i] = wantSrc[i] && ((pathEn & ~(NUM_SRC'(1) << i)) == '0);
    end
    strobes.pathReq[SRC_RING] = strobes.pathReq[SRC_RING] & settleDone;
  end

  // PLL power guard
  assign pllInUse = wantSrc[SRC_PLL] | pathEn[SRC_PLL];
  assign pllEnOut = pllEnReq | pllInUse;

  always_ff @(posedge clkPll or negedge rstN) begin
    if (!rstN)                      pllErr <= 1'b0;
    else if (pllInUse && !pllEnReq) pllErr <= 1'b1;
  end
endmodule

// File: rtl/clk_source_sel_path.sv
`timescale 1ns/1ps
module clk_source_sel_path
  import clk_source_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic [NUM_SRC-1:0] srcClk,
  input  logic               rstN,
  input  selStrobes_t        strobes,
  output logic [NUM_SRC-1:0] pathEn,
  output logic               clkOut
);
  logic [NUM_SRC-1:0] gated;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_path
    logic [SYNC_STAGES-1:0] syncQ;
    // falling-edge sync: the gate moves only while this clock is low
    always_ff @(negedge srcClk[i] or negedge rstN) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= {syncQ[SYNC_STAGES-2:0], strobes.pathReq[i]};
    end
    assign pathEn[i] = syncQ[SYNC_STAGES-1];
    assign gated[i]  = srcClk[i] & pathEn[i];
  end

  assign clkOut = |gated;
endmodule

// File: rtl/clk_source_sel.sv
`timescale 1ns/1ps
module clk_source_sel
  import clk_source_sel_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clkExt,
  input  logic       clkPll,
  input  logic       clkRing,
  input  logic       rstN,
  input  logic       slowSel,
  input  logic       pllSel,
  input  logic       pllEnReq,
  output logic       oscEn,
  output logic       pllEnOut,
  output logic       clkOut,
  output logic [2:0] srcActive,
  output logic       pllErr
);
  selStrobes_t        strobes;
  logic [NUM_SRC-1:0] pathEn;
  logic               settleDone;

  clk_source_sel_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clkPll    (clkPll),
    .clkRing   (clkRing),
    .rstN      (rstN),
    .slowSel   (slowSel),
    .pllSel    (pllSel),
    .pllEnReq  (pllEnReq),
    .pathEn    (pathEn),
    .strobes   (strobes),
    .oscEn     (oscEn),
    .pllEnOut  (pllEnOut),
    .pllErr    (pllErr),
    .settleDone(settleDone)
  );

  clk_source_sel_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
    .srcClk ({clkRing, clkPll, clkExt}),
    .rstN   (rstN),
    .strobes(strobes),
    .pathEn (pathEn),
    .clkOut (clkOut)
  );

  assign srcActive = pathEn;
endmodule

// File: rtl/clk_source_sel_checker.sv
`timescale 1ns/1ps
module clk_source_sel_checker (
  input logic       clkExt,
  input logic       rstN,
  input logic [2:0] srcActive,
  input logic       oscEn,
  input logic       pllEnOut,
  input logic       pllErr,
  input logic       settleDone
);
  AST_ONE_SOURCE: assert property (@(posedge clkExt) disable iff (!rstN)
    $onehot0(srcActive));                                   // R6
  AST_RING_POWERED: assert property (@(posedge clkExt) disable iff (!rstN)
    srcActive[2] |-> oscEn);                                // R5
  AST_RING_SETTLED: assert property (@(posedge clkExt) disable iff (!rstN)
    srcActive[2] |-> settleDone);                           // R7
  AST_PLL_HELD: assert property (@(posedge clkExt) disable iff (!rstN)
    srcActive[1] |-> pllEnOut);                             // R8
  AST_ERR_STICKY: assert property (@(posedge clkExt) disable iff (!rstN)
    pllErr |=> pllErr);                                     // R9
endmodule

bind clk_source_sel clk_source_sel_checker u_checker (
  .clkExt    (clkExt),
  .rstN      (rstN),
  .srcActive (srcActive),
  .oscEn     (oscEn),
  .pllEnOut  (pllEnOut),
  .pllErr    (pllErr),
  .settleDone(settleDone)
);

// File: tb/clk_source_sel_bench.sv
`timescale 1ns/1ps
module clk_source_sel_bench;
  localparam int  SETTLE   = 8;
  localparam real EXT_PER  = 5.0;
  localparam real PLL_PER  = 4.0;
  localparam real RING_PER = 14.0;

  logic clkExt = 1'b0, clkPll = 1'b0, clkRing = 1'b0;
  logic rstN = 1'b0, slowSel = 1'b0, pllSel = 1'b0, pllEnReq = 1'b1;
  logic oscEn, pllEnOut, clkOut, pllErr;
  logic [2:0] srcActive;

  int checks = 0, fails = 0, glitches = 0;
  logic [2:0] expQ[$];
  bit monBusy = 0;
  realtime lastRise = -1.0, lastFall = -1.0, oscRiseT = 0.0, ringOnT = 0.0;

  clk_source_sel #(.SETTLE_CYCLES(SETTLE)) u_clk_source_sel (
    .clkExt(clkExt), .clkPll(clkPll), .clkRing(clkRing), .rstN(rstN),
    .slowSel(slowSel), .pllSel(pllSel), .pllEnReq(pllEnReq),
    .oscEn(oscEn), .pllEnOut(pllEnOut), .clkOut(clkOut),
    .srcActive(srcActive), .pllErr(pllErr)
  );

  always #2.5 clkExt = ~clkExt;
  initial forever begin
    #2; if (pllEnOut) clkPll = ~clkPll; else clkPll = 1'b0;
  end
  initial forever begin
    #7; if (oscEn) clkRing = ~clkRing; else clkRing = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // pulse-width monitor for R6
  always @(posedge clkOut) begin
    if (rstN && lastFall >= 0.0 && ($realtime - lastFall) < 1.9) glitches++;
    lastRise = $realtime;
  end
  always @(negedge clkOut) begin
    if (rstN && lastRise >= 0.0 && ($realtime - lastRise) < 1.9) glitches++;
    lastFall = $realtime;
  end
  always @(posedge oscEn)       oscRiseT = $realtime;
  always @(posedge srcActive[2]) ringOnT = $realtime;

  // driver: push expectation, then apply selection
  task automatic setSel(input logic s, input logic p, input logic [2:0] exp);
    expQ.push_back(exp);
    slowSel = s; pllSel = p;
    #1;
    wait (expQ.size() == 0 && !monBusy);
  endtask

  // monitor: pop expectation, wait for the status, measure the period
  initial forever begin
    logic [2:0] exp;
    realtime t0, t1, wantPer;
    int n;
    wait (expQ.size() > 0);
    monBusy = 1;
    exp = expQ.pop_front();
    n = 0;
    while (srcActive !== exp && n < 2000) begin #1; n++; end
    chk(srcActive === exp, exp[2] ? "R4" : exp[1] ? "R3" : "R2",
        "srcActive", int'(srcActive), int'(exp));
    wantPer = exp[2] ? RING_PER : exp[1] ? PLL_PER : EXT_PER;
    @(posedge clkOut); t0 = $realtime;
    @(posedge clkOut); t1 = $realtime;
    chk((t1 - t0) > wantPer - 0.05 && (t1 - t0) < wantPer + 0.05,
        exp[2] ? "R4" : exp[1] ? "R3" : "R2", "clkOut period x10ps",
        int'((t1 - t0) * 100.0), int'(wantPer * 100.0));
    monBusy = 0;
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #41.0;
    chk(srcActive == 3'b000, "R1", "srcActive in reset", srcActive, 0);
    chk(clkOut == 1'b0, "R1", "clkOut in reset", clkOut, 0);
    chk(pllErr == 1'b0 && oscEn == 1'b0, "R1", "pllErr/oscEn in reset",
        {pllErr, oscEn}, 0);
    rstN = 1'b1;

    setSel(0, 0, 3'b001);                                   // R2
    chk(oscEn == 1'b0, "R5", "oscEn with ext", oscEn, 0);
    chk(pllEnOut == 1'b1, "R8", "pllEnOut follows request", pllEnOut, 1);

    setSel(0, 1, 3'b010);                                   // R3
    pllEnReq = 1'b0;
    #50;
    chk(pllEnOut == 1'b1, "R8", "PLL held while active", pllEnOut, 1);
    chk(pllErr == 1'b1, "R9", "error on PLL power-down in use", pllErr, 1);

    setSel(0, 0, 3'b001);                                   // R2
    #50;
    chk(pllEnOut == 1'b0, "R8", "pllEnOut drops once PLL unused", pllEnOut, 0);
    chk(pllErr == 1'b1, "R9", "error stays set", pllErr, 1);
    pllEnReq = 1'b1;

    setSel(1, 0, 3'b100);                                   // R4
    chk(oscEn == 1'b1, "R5", "oscEn with ring", oscEn, 1);
    chk((ringOnT - oscRiseT) >= (SETTLE - 0.5) * RING_PER, "R7",
        "settle delay ns", int'(ringOnT - oscRiseT), int'((SETTLE - 0.5) * RING_PER));

    setSel(1, 1, 3'b100);                                   // R4 override
    setSel(0, 1, 3'b010);                                   // R3
    #50;
    chk(oscEn == 1'b0, "R5", "oscEn off after leaving ring", oscEn, 0);

    setSel(1, 1, 3'b100);                                   // R4
    setSel(0, 0, 3'b001);                                   // R2

    pllEnReq = 1'b0;
    setSel(0, 1, 3'b010);
    #30;
    rstN = 1'b0;
    pllEnReq = 1'b1;
    #20;
    chk(pllErr == 1'b0, "R9", "reset clears error", pllErr, 0);
    chk(srcActive == 3'b000 && clkOut == 1'b0, "R1", "second reset state",
        {srcActive, clkOut}, 0);
    slowSel = 1'b0; pllSel = 1'b0;
    rstN = 1'b1;
    setSel(0, 0, 3'b001);

    chk(glitches == 0, "R6", "short output phases", glitches, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule